// File: doc/BRIEF.md
# Time-Slot Interchange with Per-Connection Delay Modes

This block moves bytes between time slots of a set of TDM lines. Received slots arrive as a stream of (line, slot, byte) words and are stored in a frame memory. The transmit side asks for one (line, slot) at a time and gets back the byte that the connection table assigns to that output position. Serialization and clock alignment are handled outside, so the block sees whole slots only.

Each line runs at one of four rates, and a line at rate code r carries `8 << r` slots per frame by default. Every table entry names a source line, a source slot, a width of 1, 2, 4 or 8 bits and a field index. It also selects constant delay (exactly two frames) or minimum delay (the newest available copy). Lines of different rates can be connected freely, because storage and lookup work in slot units. A frame-sync pulse rotates a three-bank frame memory. Software fills the table and the line rates through a single write-only register port.

Top module: `tsi_switch`

## Requirements
- R1: After reset `tx_valid` is 0, `tx_data` is 8'hFF, every line rate code is 0 and every output slot is unconnected.
- R2: A request accepted with `tx_req` high on a clock edge produces `tx_valid` high with its byte on `tx_data` exactly three edges later. `tx_valid` is low in all other cycles.
- R3: `tx_data` is 8'hFF whenever `tx_valid` is low, and also for a request to an output slot whose entry is disabled.
- R4: An enabled 8-bit constant-delay connection returns the byte received on its source slot two frame-sync pulses before the current frame.
- R5: An enabled 8-bit minimum-delay connection behaves as follows. If the source slot has been received since the last frame sync, the connection returns that byte; otherwise it returns the previous frame's byte. A byte received in the same cycle as the frame sync belongs to the new frame.
- R6: The width code is `cfg_wdata[3:2]` (0=1 bit, 1=2 bits, 2=4 bits, 3=8 bits) and the field index is `cfg_wdata[6:4]`. Fields are numbered from the MSB, e.g. width 1 index 1 covers bits [5:4]. The selected source bits appear at the same position in the output byte and all other output bits are 1.
- R7: A connection narrower than 8 bits always uses two-frame constant delay, even when its minimum-delay bit `cfg_wdata[1]` is set.
- R8: A write that enables a sub-byte connection is refused, leaving the entry unchanged, if either its output line or its source line has rate code 3.
- R9: A line with rate code r has `8 << r` valid slots. A request to a slot beyond its line's count returns 8'hFF, and a received word beyond its line's count is dropped. Lines of different rates connect freely.
- R10: With `cfg_rate_sel`=0, a write to `{cfg_line,cfg_slot}` stores enable `cfg_wdata[0]`, source line `cfg_wdata[8:7]` and source slot `cfg_wdata[14:9]`. With `cfg_rate_sel`=1, it sets the rate of `cfg_line` to `cfg_wdata[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs | input | 1 | Frame-sync pulse; starts a new frame |
| rx_valid | input | 1 | Received slot word present |
| rx_line | input | 2 | Received line number |
| rx_slot | input | 6 | Received slot number |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Transmit lookup request |
| tx_line | input | 2 | Output line of the request |
| tx_slot | input | 6 | Output slot of the request |
| tx_valid | output | 1 | Lookup result present |
| tx_data | output | 8 | Byte for the requested output slot |
| cfg_we | input | 1 | Register write strobe |
| cfg_rate_sel | input | 1 | 1 = write a line rate, 0 = write a table entry |
| cfg_line | input | 2 | Output line addressed by the write |
| cfg_slot | input | 6 | Output slot addressed by the write |
| cfg_wdata | input | 15 | Write data |

## Verification
Every lookup result is due exactly three clock edges after its request, through the table read, the frame-memory read and the output formatting register. Each query therefore drives the request on a falling edge and samples `tx_valid` and `tx_data` on the third falling edge after it. Delay behaviour is judged in frames rather than cycles. Each expected byte is the value the bench wrote zero, one or two frame-sync pulses earlier, chosen from the requirement for the connection's mode. Frame-sync pulses are never issued while a lookup is in flight, so the bank each lookup reads is fixed when it starts.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam logic [1:0] WIDTH_FULL = 2'd3;
  localparam logic [1:0] RATE_TOP   = 2'd3;

  // Mask of the field picked by a width code and an index counted from the MSB.
  function automatic logic [7:0] sub_mask(input logic [1:0] w, input logic [2:0] idx);
    case (w)
      2'd0:    return 8'h80 >> idx;
      2'd1:    return 8'hC0 >> {idx[1:0], 1'b0};
      2'd2:    return 8'hF0 >> {idx[0], 2'b00};
      default: return 8'hFF;
    endcase
  endfunction

  // True when a slot number lies inside the count allowed by a rate code.
  function automatic logic slot_ok(input int slot, input logic [1:0] rate, input int base_bits);
    return (slot >> (base_bits + int'(rate))) == 0;
  endfunction

endpackage

// File: rtl/tsi_conn_table.sv
module tsi_conn_table
  import tsi_pkg::*;
#(
  parameter int LINE_BITS = 2,
  parameter int BASE_SLOT_BITS = 3,
  localparam int SLOT_BITS = BASE_SLOT_BITS + 3,
  localparam int NLINES = 1 << LINE_BITS,
  localparam int DEPTH = NLINES << SLOT_BITS,
  localparam int CW = 7 + LINE_BITS + SLOT_BITS,
  localparam int EW = CW - 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic                         cfg_rate_sel,
  input  logic [LINE_BITS-1:0]         cfg_line,
  input  logic [SLOT_BITS-1:0]         cfg_slot,
  input  logic [CW-1:0]                cfg_wdata,
  input  logic                         tx_req,
  input  logic [LINE_BITS-1:0]         tx_line,
  input  logic [SLOT_BITS-1:0]         tx_slot,
  output logic [NLINES-1:0][1:0]       rates,
  output logic                         lk_valid,
  output logic                         lk_en,
  output logic [EW-1:0]                lk_word
);

  logic [EW-1:0]    tbl [DEPTH];
  logic [DEPTH-1:0] en_bits;

  logic [LINE_BITS-1:0] src_line;
  logic                 narrow, refuse, tbl_we;

  always_comb begin
    src_line = cfg_wdata[7 +: LINE_BITS];
    narrow   = cfg_wdata[3:2] != WIDTH_FULL;
    refuse   = cfg_wdata[0] && narrow &&
               (rates[cfg_line] == RATE_TOP || rates[src_line] == RATE_TOP);
    tbl_we   = cfg_we && !cfg_rate_sel && !refuse;
  end

  // Entry storage and registered lookup, no reset so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (tbl_we) tbl[{cfg_line, cfg_slot}] <= cfg_wdata[CW-1:1];
    if (tx_req) lk_word <= tbl[{tx_line, tx_slot}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_bits  <= '0;
      rates    <= '0;
      lk_valid <= 1'b0;
      lk_en    <= 1'b0;
    end else begin
      if (tbl_we) en_bits[{cfg_line, cfg_slot}] <= cfg_wdata[0];
      if (cfg_we && cfg_rate_sel) rates[cfg_line] <= cfg_wdata[1:0];
      lk_valid <= tx_req;
      lk_en    <= en_bits[{tx_line, tx_slot}] &&
                  slot_ok(int'(tx_slot), rates[tx_line], BASE_SLOT_BITS);
    end
  end

endmodule

// File: rtl/tsi_frame_store.sv
module tsi_frame_store
  import tsi_pkg::*;
#(
  parameter int LINE_BITS = 2,
  parameter int BASE_SLOT_BITS = 3,
  localparam int SLOT_BITS = BASE_SLOT_BITS + 3,
  localparam int NLINES = 1 << LINE_BITS,
  localparam int KW = LINE_BITS + SLOT_BITS,
  localparam int DEPTH = 1 << KW,
  localparam int EW = 6 + LINE_BITS + SLOT_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fs,
  input  logic                   rx_valid,
  input  logic [LINE_BITS-1:0]   rx_line,
  input  logic [SLOT_BITS-1:0]   rx_slot,
  input  logic [7:0]             rx_data,
  input  logic [NLINES-1:0][1:0] rates,
  input  logic                   lk_valid,
  input  logic                   lk_en,
  input  logic [EW-1:0]          lk_word,
  output logic                   rd_valid,
  output logic                   rd_en,
  output logic [1:0]             rd_w,
  output logic [2:0]             rd_idx,
  output logic [7:0]             rd_byte,
  output logic [1:0]             wbank
);

  logic [7:0]       mem [3*DEPTH];
  logic [DEPTH-1:0] seen;

  logic [1:0]    bank_nxt, bank_prv, wr_bank, rd_bank;
  logic          rx_ok, lk_min;
  logic [1:0]    lk_w;
  logic [KW-1:0] rx_key, lk_key;

  always_comb begin
    bank_nxt = (wbank == 2'd2) ? 2'd0 : wbank + 2'd1;
    bank_prv = (wbank == 2'd0) ? 2'd2 : wbank - 2'd1;
    wr_bank  = fs ? bank_nxt : wbank;
    rx_key   = {rx_line, rx_slot};
    rx_ok    = rx_valid && slot_ok(int'(rx_slot), rates[rx_line], BASE_SLOT_BITS);
    lk_w     = lk_word[2:1];
    lk_min   = lk_word[0] && (lk_w == WIDTH_FULL);
    lk_key   = {lk_word[6 +: LINE_BITS], lk_word[6+LINE_BITS +: SLOT_BITS]};
    // The bank after the write bank was written two frames ago.
    if (lk_min) rd_bank = seen[lk_key] ? wbank : bank_prv;
    else        rd_bank = bank_nxt;
  end

  always_ff @(posedge clk) begin
    if (rx_ok)    mem[{wr_bank, rx_key}] <= rx_data;
    if (lk_valid) rd_byte <= mem[{rd_bank, lk_key}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbank    <= 2'd0;
      seen     <= '0;
      rd_valid <= 1'b0;
      rd_en    <= 1'b0;
      rd_w     <= WIDTH_FULL;
      rd_idx   <= 3'd0;
    end else begin
      if (fs)    wbank <= bank_nxt;
      if (fs)    seen <= '0;
      if (rx_ok) seen[rx_key] <= 1'b1;
      rd_valid <= lk_valid;
      rd_en    <= lk_en;
      rd_w     <= lk_w;
      rd_idx   <= lk_word[5:3];
    end
  end

endmodule

// File: rtl/tsi_out_fmt.sv
module tsi_out_fmt
  import tsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_valid,
  input  logic       rd_en,
  input  logic [1:0] rd_w,
  input  logic [2:0] rd_idx,
  input  logic [7:0] rd_byte,
  output logic       tx_valid,
  output logic [7:0] tx_data
);

  logic [7:0] mask;

  always_comb mask = sub_mask(rd_w, rd_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'hFF;
    end else begin
      tx_valid <= rd_valid;
      tx_data  <= (rd_valid && rd_en) ? ((rd_byte & mask) | ~mask) : 8'hFF;
    end
  end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int LINE_BITS = 2,
  parameter int BASE_SLOT_BITS = 3,
  localparam int SLOT_BITS = BASE_SLOT_BITS + 3,
  localparam int NLINES = 1 << LINE_BITS,
  localparam int CW = 7 + LINE_BITS + SLOT_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fs,
  input  logic                 rx_valid,
  input  logic [LINE_BITS-1:0] rx_line,
  input  logic [SLOT_BITS-1:0] rx_slot,
  input  logic [7:0]           rx_data,
  input  logic                 tx_req,
  input  logic [LINE_BITS-1:0] tx_line,
  input  logic [SLOT_BITS-1:0] tx_slot,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  input  logic                 cfg_we,
  input  logic                 cfg_rate_sel,
  input  logic [LINE_BITS-1:0] cfg_line,
  input  logic [SLOT_BITS-1:0] cfg_slot,
  input  logic [CW-1:0]        cfg_wdata
);

  logic [NLINES-1:0][1:0] rates;
  logic                   lk_valid, lk_en;
  logic [CW-2:0]          lk_word;
  logic                   rd_valid, rd_en;
  logic [1:0]             rd_w, wbank;
  logic [2:0]             rd_idx;
  logic [7:0]             rd_byte;

  tsi_conn_table #(.LINE_BITS(LINE_BITS), .BASE_SLOT_BITS(BASE_SLOT_BITS)) table_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_rate_sel(cfg_rate_sel),
    .cfg_line(cfg_line), .cfg_slot(cfg_slot), .cfg_wdata(cfg_wdata),
    .tx_req(tx_req), .tx_line(tx_line), .tx_slot(tx_slot),
    .rates(rates), .lk_valid(lk_valid), .lk_en(lk_en), .lk_word(lk_word)
  );

  tsi_frame_store #(.LINE_BITS(LINE_BITS), .BASE_SLOT_BITS(BASE_SLOT_BITS)) store_i (
    .clk(clk), .rst(rst), .fs(fs), .rx_valid(rx_valid), .rx_line(rx_line),
    .rx_slot(rx_slot), .rx_data(rx_data), .rates(rates), .lk_valid(lk_valid),
    .lk_en(lk_en), .lk_word(lk_word), .rd_valid(rd_valid), .rd_en(rd_en),
    .rd_w(rd_w), .rd_idx(rd_idx), .rd_byte(rd_byte), .wbank(wbank)
  );

  tsi_out_fmt fmt_i (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_en(rd_en), .rd_w(rd_w),
    .rd_idx(rd_idx), .rd_byte(rd_byte), .tx_valid(tx_valid), .tx_data(tx_data)
  );

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk (
  input logic       clk,
  input logic       rst,
  input logic       fs,
  input logic       tx_req,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic [1:0] wbank
);

  // R2: a request yields a result three edges later, and only then.
  a_r2_result_due: assert property (@(posedge clk) disable iff (rst)
    $past(tx_req, 3) |-> tx_valid);
  a_r2_no_stray: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(tx_req, 3));

  // R3: idle output carries all ones.
  a_r3_idle_ones: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |-> tx_data == 8'hFF);

  // R4: frame banks advance by one, modulo three, on each sync and hold otherwise.
  a_r4_bank_step: assert property (@(posedge clk) disable iff (rst)
    fs |=> wbank == (($past(wbank) == 2'd2) ? 2'd0 : $past(wbank) + 2'd1));
  a_r4_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !fs |=> $stable(wbank));
  a_r4_bank_range: assert property (@(posedge clk) disable iff (rst)
    wbank != 2'd3);

endmodule

bind tsi_switch tsi_switch_chk chk_i (
  .clk(clk), .rst(rst), .fs(fs), .tx_req(tx_req),
  .tx_valid(tx_valid), .tx_data(tx_data), .wbank(wbank)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb_top;

  localparam int LB = 2;
  localparam int SB = 6;
  localparam int CW = 7 + LB + SB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fs = 1'b0;
  logic          rx_valid = 1'b0;
  logic [LB-1:0] rx_line = '0;
  logic [SB-1:0] rx_slot = '0;
  logic [7:0]    rx_data = '0;
  logic          tx_req = 1'b0;
  logic [LB-1:0] tx_line = '0;
  logic [SB-1:0] tx_slot = '0;
  logic          tx_valid;
  logic [7:0]    tx_data;
  logic          cfg_we = 1'b0;
  logic          cfg_rate_sel = 1'b0;
  logic [LB-1:0] cfg_line = '0;
  logic [SB-1:0] cfg_slot = '0;
  logic [CW-1:0] cfg_wdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tsi_switch dut_i (
    .clk(clk), .rst(rst), .fs(fs), .rx_valid(rx_valid), .rx_line(rx_line),
    .rx_slot(rx_slot), .rx_data(rx_data), .tx_req(tx_req), .tx_line(tx_line),
    .tx_slot(tx_slot), .tx_valid(tx_valid), .tx_data(tx_data), .cfg_we(cfg_we),
    .cfg_rate_sel(cfg_rate_sel), .cfg_line(cfg_line), .cfg_slot(cfg_slot),
    .cfg_wdata(cfg_wdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_rate(input int line, input int rate);
    cfg_we = 1'b1; cfg_rate_sel = 1'b1; cfg_line = LB'(line);
    cfg_wdata = CW'(rate);
    @(negedge clk);
    cfg_we = 1'b0; cfg_rate_sel = 1'b0;
  endtask

  // R10 encoding: {src_slot, src_line, idx, width, min, en}
  task automatic connect(input int ol, input int os, input bit en, input bit mn,
                         input int w, input int idx, input int sl, input int ss);
    cfg_we = 1'b1; cfg_rate_sel = 1'b0; cfg_line = LB'(ol); cfg_slot = SB'(os);
    cfg_wdata = {SB'(ss), LB'(sl), 3'(idx), 2'(w), mn, en};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rx(input int line, input int slot, input logic [7:0] d, input bit with_fs);
    rx_valid = 1'b1; rx_line = LB'(line); rx_slot = SB'(slot); rx_data = d; fs = with_fs;
    @(negedge clk);
    rx_valid = 1'b0; fs = 1'b0;
  endtask

  task automatic fsync();
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
    @(negedge clk);
  endtask

  task automatic query(input int line, input int slot, input logic [7:0] exp, input string req);
    tx_req = 1'b1; tx_line = LB'(line); tx_slot = SB'(slot);
    @(negedge clk);
    tx_req = 1'b0;
    repeat (2) @(negedge clk);
    check({req, " valid"}, {7'd0, tx_valid}, 8'd1);
    check(req, tx_data, exp);
  endtask

  task automatic t_reset();
    check("R1 tx_valid after reset", {7'd0, tx_valid}, 8'd0);
    check("R1 tx_data after reset", tx_data, 8'hFF);
    query(0, 0, 8'hFF, "R1 R3 unconnected after reset");
    query(2, 4, 8'hFF, "R3 unconnected slot");
  endtask

  task automatic t_latency();
    tx_req = 1'b1; tx_line = 2'd1; tx_slot = 6'd2;
    @(negedge clk);
    tx_req = 1'b0;
    @(negedge clk);
    check("R2 not yet valid", {7'd0, tx_valid}, 8'd0);
    check("R3 ones while idle", tx_data, 8'hFF);
    @(negedge clk);
    check("R2 valid on third edge", {7'd0, tx_valid}, 8'd1);
    @(negedge clk);
    check("R2 valid one cycle only", {7'd0, tx_valid}, 8'd0);
  endtask

  task automatic t_const();
    connect(1, 3, 1, 0, 3, 0, 0, 5);
    fsync(); rx(0, 5, 8'hA1, 0);
    fsync(); rx(0, 5, 8'hB2, 0);
    fsync(); rx(0, 5, 8'hC3, 0);
    query(1, 3, 8'hA1, "R4 two frames back");
    fsync(); rx(0, 5, 8'hD4, 0);
    query(1, 3, 8'hB2, "R4 next frame");
  endtask

  task automatic t_min();
    connect(2, 1, 1, 1, 3, 0, 0, 6);
    fsync(); rx(0, 6, 8'h11, 0);
    query(2, 1, 8'h11, "R5 same frame");
    fsync();
    query(2, 1, 8'h11, "R5 previous frame");
    rx(0, 6, 8'h22, 0);
    query(2, 1, 8'h22, "R5 after arrival");
    @(negedge clk);
    rx(0, 6, 8'h33, 1);
    @(negedge clk);
    query(2, 1, 8'h33, "R5 arrival with sync");
  endtask

  task automatic t_sub();
    connect(3, 0, 1, 1, 1, 1, 1, 2);
    fsync(); rx(1, 2, 8'h96, 0);
    fsync(); rx(1, 2, 8'h00, 0);
    fsync(); rx(1, 2, 8'h00, 0);
    query(3, 0, 8'hDF, "R7 narrow ignores min flag");
    connect(3, 0, 1, 0, 2, 0, 1, 2);
    query(3, 0, 8'h9F, "R6 4-bit upper field");
    connect(3, 0, 1, 0, 0, 7, 1, 2);
    query(3, 0, 8'hFE, "R6 1-bit lsb field");
    connect(3, 0, 1, 0, 1, 3, 1, 2);
    query(3, 0, 8'hFE, "R6 2-bit low field");
    connect(3, 0, 1, 0, 3, 0, 1, 2);
    query(3, 0, 8'h96, "R4 full byte two frames back");
    connect(3, 0, 0, 0, 3, 0, 1, 2);
    query(3, 0, 8'hFF, "R3 disabled entry");
  endtask

  task automatic t_rates();
    set_rate(3, 3);
    connect(3, 5, 1, 0, 1, 0, 0, 1);
    query(3, 5, 8'hFF, "R8 narrow on fast output refused");
    connect(0, 3, 1, 0, 0, 0, 3, 0);
    query(0, 3, 8'hFF, "R8 narrow from fast source refused");
    connect(3, 40, 1, 1, 3, 0, 0, 1);
    connect(2, 7, 1, 1, 3, 0, 0, 1);
    fsync(); rx(0, 1, 8'h5A, 0);
    query(3, 40, 8'h5A, "R9 slow to fast high slot");
    connect(2, 7, 1, 0, 0, 0, 3, 0);
    query(2, 7, 8'h5A, "R8 refused write leaves entry");
    connect(0, 9, 1, 1, 3, 0, 0, 1);
    query(0, 9, 8'hFF, "R9 slot beyond rate count");
    set_rate(0, 1);
    query(0, 9, 8'h5A, "R9 slot valid after rate raise");
    connect(1, 6, 1, 1, 3, 0, 0, 12);
    fsync(); rx(0, 12, 8'h77, 0);
    fsync();
    set_rate(0, 0);
    rx(0, 12, 8'h33, 0);
    query(1, 6, 8'h77, "R9 out-of-range receive dropped");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_const();
    t_min();
    t_sub();
    t_rates();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule